// File: doc/BRIEF.md
# Asynchronous HDLC Receive Frame Status Controller

This block sits after a byte-oriented asynchronous receiver. It takes the stream of received characters and finds the frame boundaries. It also removes the control-escape coding and turns every way a frame can end into a single frame-close pulse with a status word. Only the first applicable error is reported, and the receiver then hunts for the next frame.

The upstream receiver supplies a byte with a valid strobe and a per-byte break indication. It also supplies a line-idle pulse, a carrier-detect level and an overrun pulse. A separate CRC checker supplies a CRC-good level, which is only consulted on the closing delimiter. A mode input chooses which byte completes the abort sequence after a control escape: one setting for point-to-point links and one for infrared links. All results leave the block through registers. The block reports break start and break end as separate pulses, apart from the frame-close path.

Top module: `hdlc_rx_frame_status`

## Requirements
- R1: After reset all outputs are low and the receiver hunts. In hunt, the byte 0x7E opens a frame and every other non-abort byte is dropped. A data byte inside an open frame appears on `data_o` with `data_vld_o` high one clock after it is accepted, and `data_o` is zero whenever `data_vld_o` is low.
- R2: A 0x7D byte is never output. The byte after it, unless it completes an abort or is 0x7E, is output XORed with 0x20, so 0x7D 0x5E gives 0x7E.
- R3: A 0x7E that follows at least one data byte of an open frame pulses `close_o` and `rxf_o` for one cycle. The status is 0 if `crc_ok_i` is high in that cycle, or only bit 0 (CRC error) if it is low. The delimiter also opens the next frame.
- R4: A 0x7E with no data byte since the previous delimiter produces no close and no event.
- R5: 0x7D followed directly by the abort byte closes with status bit 2 (abort) only, with or without an open frame, and the CRC is not evaluated. The abort byte is 0x7E when `mode_i`=0 and 0xC1 when `mode_i`=1. The receiver then hunts.
- R6: When `carrier_i` is low and the frame holds data, the block closes with status bit 4 (carrier lost) only. Frame input is ignored while carrier is low and in the first cycle it is high again. After that the receiver hunts.
- R7: `ovr_i` high with carrier present discards that cycle's byte. If the frame holds data it closes with status bit 3 (overrun) only. The receiver then hunts.
- R8: A valid byte with `rx_brk_i` high closes a frame holding data with status bit 1 (break) only, with no CRC check, and the receiver hunts. `brk_start_o` pulses only for the first break character of a sequence.
- R9: After a break sequence, the first non-break valid byte or `line_idle_i` pulse (carrier present, no overrun for the byte) pulses `brk_end_o` once.
- R10: When several conditions meet in one cycle, the single status bit set follows the order carrier lost, overrun, abort or break, CRC. No break event is raised for a byte discarded by overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Abort byte select: 0 gives 0x7E, 1 gives 0xC1 |
| rx_vld_i | input | 1 | Received byte valid |
| rx_byte_i | input | BW | Received byte |
| rx_brk_i | input | 1 | The valid character is a break |
| line_idle_i | input | 1 | Idle bit seen on the line |
| carrier_i | input | 1 | Carrier detect level |
| ovr_i | input | 1 | Receive FIFO overrun pulse |
| crc_ok_i | input | 1 | CRC check passed, sampled on the closing delimiter |
| close_o | output | 1 | Frame-close pulse |
| status_o | output | 5 | Close status: bit0 CRC, bit1 break, bit2 abort, bit3 overrun, bit4 carrier lost |
| rxf_o | output | 1 | Receive-frame event pulse |
| brk_start_o | output | 1 | Break sequence start event |
| brk_end_o | output | 1 | Break sequence end event |
| data_vld_o | output | 1 | Unescaped data byte valid |
| data_o | output | BW | Unescaped data byte |

## Verification
Every result of this block is due on exactly one rising edge after the cycle whose inputs cause it. This covers data bytes, frame closes with their status, and break start and end pulses. The bench changes inputs only at falling edges and steps its reference model once per driven cycle. It compares all outputs 1 ns after the following rising edge, so an output a cycle early or late shows up as a mismatch. Cycles where carrier loss, overrun, break and abort coincide are driven on purpose, so the priority order is checked against the model's single expected status bit.

// File: rtl/hdlc_rxs_pkg.sv
package hdlc_rxs_pkg;
   localparam int STAT_W  = 5;
   localparam int ST_CRC  = 0;
   localparam int ST_BRK  = 1;
   localparam int ST_ABT  = 2;
   localparam int ST_OVR  = 3;
   localparam int ST_CDL  = 4;

   typedef enum logic [1:0] {
      RX_HUNT   = 2'd0,
      RX_OPEN   = 2'd1,
      RX_CDWAIT = 2'd2
   } rx_state_e;

   function automatic logic [STAT_W-1:0] stat_bit(input int idx);
      logic [STAT_W-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/hdlc_rxs_char_class.sv
module hdlc_rxs_char_class #(
   parameter int          BW        = 8,
   parameter int unsigned FLAG_CODE = 8'h7E,
   parameter int unsigned ESC_CODE  = 8'h7D,
   parameter int unsigned ABT_A     = 8'h7E,
   parameter int unsigned ABT_B     = 8'hC1,
   parameter int unsigned XOR_MASK  = 8'h20,
   parameter int          ABORT_SEL = 0
) (
   input  logic [BW-1:0] byte_i,
   input  logic          esc_i,
   input  logic          mode_i,
   output logic          is_abort_o,
   output logic          is_flag_o,
   output logic          is_esc_o,
   output logic [BW-1:0] value_o
);
   localparam logic [BW-1:0] FLAG_V = BW'(FLAG_CODE);
   localparam logic [BW-1:0] ESC_V  = BW'(ESC_CODE);
   localparam logic [BW-1:0] ABT_AV = BW'(ABT_A);
   localparam logic [BW-1:0] ABT_BV = BW'(ABT_B);
   localparam logic [BW-1:0] MASK_V = BW'(XOR_MASK);

   logic [BW-1:0] abort_code;

   generate
      if (ABORT_SEL == 1) begin : g_fixed_a
         assign abort_code = ABT_AV;
      end else if (ABORT_SEL == 2) begin : g_fixed_b
         assign abort_code = ABT_BV;
      end else begin : g_runtime
         assign abort_code = mode_i ? ABT_BV : ABT_AV;
      end
   endgenerate

   always_comb begin
      is_abort_o = esc_i && (byte_i == abort_code);
      is_flag_o  = !is_abort_o && (byte_i == FLAG_V);
      is_esc_o   = !is_abort_o && !is_flag_o && !esc_i && (byte_i == ESC_V);
      value_o    = esc_i ? (byte_i ^ MASK_V) : byte_i;
   end
endmodule

// File: rtl/hdlc_rxs_break_track.sv
module hdlc_rxs_break_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic carrier_i,
   input  logic ovr_i,
   input  logic vld_i,
   input  logic brk_i,
   input  logic idle_i,
   output logic start_o,
   output logic end_o
);
   logic act_q;
   logic brk_ev;
   logic end_ev;

   always_comb begin
      brk_ev = carrier_i && !ovr_i && vld_i && brk_i;
      end_ev = carrier_i && !brk_ev && ((!ovr_i && vld_i && !brk_i) || idle_i);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_q   <= 1'b0;
         start_o <= 1'b0;
         end_o   <= 1'b0;
      end else begin
         start_o <= brk_ev && !act_q;
         end_o   <= end_ev && act_q;
         if (brk_ev)      act_q <= 1'b1;
         else if (end_ev) act_q <= 1'b0;
      end
   end
endmodule

// File: rtl/hdlc_rxs_frame_ctl.sv
module hdlc_rxs_frame_ctl
   import hdlc_rxs_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              carrier_i,
   input  logic              ovr_i,
   input  logic              vld_i,
   input  logic              brk_i,
   input  logic              crc_ok_i,
   input  logic              is_abort_i,
   input  logic              is_flag_i,
   input  logic              is_esc_i,
   input  logic [BW-1:0]     value_i,
   output logic              esc_o,
   output logic              close_o,
   output logic [STAT_W-1:0] status_o,
   output logic              data_vld_o,
   output logic [BW-1:0]     data_o
);
   rx_state_e         st_q, st_d;
   logic              has_q, has_d;
   logic              esc_q, esc_d;
   logic              close_d;
   logic [STAT_W-1:0] stat_d;
   logic              dv_d;
   logic [BW-1:0]     dd_d;

   assign esc_o = esc_q;

   always_comb begin
      st_d    = st_q;
      has_d   = has_q;
      esc_d   = esc_q;
      close_d = 1'b0;
      stat_d  = '0;
      dv_d    = 1'b0;
      dd_d    = '0;
      if (st_q == RX_CDWAIT) begin
         if (carrier_i) st_d = RX_HUNT;
      end else if (!carrier_i) begin
         close_d = has_q;
         stat_d  = has_q ? stat_bit(ST_CDL) : '0;
         st_d    = RX_CDWAIT;
         has_d   = 1'b0;
         esc_d   = 1'b0;
      end else if (ovr_i) begin
         close_d = has_q;
         stat_d  = has_q ? stat_bit(ST_OVR) : '0;
         st_d    = RX_HUNT;
         has_d   = 1'b0;
         esc_d   = 1'b0;
      end else if (vld_i && brk_i) begin
         close_d = has_q;
         stat_d  = has_q ? stat_bit(ST_BRK) : '0;
         st_d    = RX_HUNT;
         has_d   = 1'b0;
         esc_d   = 1'b0;
      end else if (vld_i) begin
         if (is_abort_i) begin
            close_d = 1'b1;
            stat_d  = stat_bit(ST_ABT);
            st_d    = RX_HUNT;
            has_d   = 1'b0;
            esc_d   = 1'b0;
         end else if (is_flag_i) begin
            esc_d = 1'b0;
            if (st_q == RX_OPEN && has_q) begin
               close_d = 1'b1;
               stat_d  = crc_ok_i ? '0 : stat_bit(ST_CRC);
            end
            st_d  = RX_OPEN;
            has_d = 1'b0;
         end else if (is_esc_i) begin
            esc_d = 1'b1;
         end else begin
            esc_d = 1'b0;
            if (st_q == RX_OPEN) begin
               dv_d  = 1'b1;
               dd_d  = value_i;
               has_d = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q       <= RX_HUNT;
         has_q      <= 1'b0;
         esc_q      <= 1'b0;
         close_o    <= 1'b0;
         status_o   <= '0;
         data_vld_o <= 1'b0;
         data_o     <= '0;
      end else begin
         st_q       <= st_d;
         has_q      <= has_d;
         esc_q      <= esc_d;
         close_o    <= close_d;
         status_o   <= stat_d;
         data_vld_o <= dv_d;
         data_o     <= dd_d;
      end
   end
endmodule

// File: rtl/hdlc_rx_frame_status.sv
module hdlc_rx_frame_status
   import hdlc_rxs_pkg::*;
#(
   parameter int          BW        = 8,
   parameter int unsigned FLAG_CODE = 8'h7E,
   parameter int unsigned ESC_CODE  = 8'h7D,
   parameter int unsigned ABT_A     = 8'h7E,
   parameter int unsigned ABT_B     = 8'hC1,
   parameter int unsigned XOR_MASK  = 8'h20,
   parameter int          ABORT_SEL = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_i,
   input  logic              rx_vld_i,
   input  logic [BW-1:0]     rx_byte_i,
   input  logic              rx_brk_i,
   input  logic              line_idle_i,
   input  logic              carrier_i,
   input  logic              ovr_i,
   input  logic              crc_ok_i,
   output logic              close_o,
   output logic [STAT_W-1:0] status_o,
   output logic              rxf_o,
   output logic              brk_start_o,
   output logic              brk_end_o,
   output logic              data_vld_o,
   output logic [BW-1:0]     data_o
);
   initial begin : elab_checks
      if (BW < 8)                  $error("BW must be at least 8");
      if (FLAG_CODE == ESC_CODE)   $error("delimiter and escape codes must differ");
      if (ABORT_SEL < 0 || ABORT_SEL > 2) $error("ABORT_SEL must be 0, 1 or 2");
      if (XOR_MASK == 0)           $error("escape mask must be nonzero");
   end

   logic          esc_w;
   logic          is_abort_w;
   logic          is_flag_w;
   logic          is_esc_w;
   logic [BW-1:0] value_w;

   hdlc_rxs_char_class #(
      .BW(BW), .FLAG_CODE(FLAG_CODE), .ESC_CODE(ESC_CODE),
      .ABT_A(ABT_A), .ABT_B(ABT_B), .XOR_MASK(XOR_MASK), .ABORT_SEL(ABORT_SEL)
   ) u_class (
      .byte_i    (rx_byte_i),
      .esc_i     (esc_w),
      .mode_i    (mode_i),
      .is_abort_o(is_abort_w),
      .is_flag_o (is_flag_w),
      .is_esc_o  (is_esc_w),
      .value_o   (value_w)
   );

   hdlc_rxs_frame_ctl #(.BW(BW)) u_frame (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .carrier_i (carrier_i),
      .ovr_i     (ovr_i),
      .vld_i     (rx_vld_i),
      .brk_i     (rx_brk_i),
      .crc_ok_i  (crc_ok_i),
      .is_abort_i(is_abort_w),
      .is_flag_i (is_flag_w),
      .is_esc_i  (is_esc_w),
      .value_i   (value_w),
      .esc_o     (esc_w),
      .close_o   (close_o),
      .status_o  (status_o),
      .data_vld_o(data_vld_o),
      .data_o    (data_o)
   );

   hdlc_rxs_break_track u_break (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .carrier_i(carrier_i),
      .ovr_i    (ovr_i),
      .vld_i    (rx_vld_i),
      .brk_i    (rx_brk_i),
      .idle_i   (line_idle_i),
      .start_o  (brk_start_o),
      .end_o    (brk_end_o)
   );

   assign rxf_o = close_o;
endmodule

// File: rtl/hdlc_rx_frame_status_chk.sv
module hdlc_rx_frame_status_chk #(
   parameter int BW = 8
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          rx_vld_i,
   input logic          carrier_i,
   input logic          ovr_i,
   input logic          close_o,
   input logic [4:0]    status_o,
   input logic          brk_start_o,
   input logic          brk_end_o,
   input logic          data_vld_o
);
   // R1: a data byte and a frame close never share a cycle
   p_data_not_close_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(data_vld_o && close_o));

   // R3: status is zero outside a close pulse
   p_status_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !close_o |-> (status_o == 5'd0));

   // R10: at most one status bit per close
   p_single_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      close_o |-> $onehot0(status_o));

   // R6: carrier low means the next cycle carries no data and only a carrier-lost close
   p_carrier_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !carrier_i |=> (!data_vld_o && (!close_o || status_o == 5'b10000)));

   // R7: overrun discards the byte and can only close with the overrun flag
   p_overrun_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (carrier_i && ovr_i) |=> (!data_vld_o && (!close_o || status_o == 5'b01000)));

   // R8: break start is a single pulse per sequence
   p_brk_start_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_start_o |=> !brk_start_o);

   // R9: break start and break end are never raised together
   p_brk_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(brk_start_o && brk_end_o));
endmodule

bind hdlc_rx_frame_status hdlc_rx_frame_status_chk #(.BW(BW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .rx_vld_i   (rx_vld_i),
   .carrier_i  (carrier_i),
   .ovr_i      (ovr_i),
   .close_o    (close_o),
   .status_o   (status_o),
   .brk_start_o(brk_start_o),
   .brk_end_o  (brk_end_o),
   .data_vld_o (data_vld_o)
);

// File: tb/hdlc_rx_frame_status_tb.sv
`timescale 1ns/1ps
module hdlc_rx_frame_status_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       mode, vld, brk, idle, cd, ovr, crc_ok;
   logic [7:0] byt;
   logic       close_w, rxf_w, bs_w, be_w, dv_w;
   logic [4:0] stat_w;
   logic [7:0] data_w;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   hdlc_rx_frame_status u_dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .rx_vld_i(vld),
      .rx_byte_i(byt), .rx_brk_i(brk), .line_idle_i(idle), .carrier_i(cd),
      .ovr_i(ovr), .crc_ok_i(crc_ok), .close_o(close_w), .status_o(stat_w),
      .rxf_o(rxf_w), .brk_start_o(bs_w), .brk_end_o(be_w),
      .data_vld_o(dv_w), .data_o(data_w)
   );

   // reference state: 0 hunt, 1 open, 2 waiting for carrier
   int         m_st  = 0;
   bit         m_has = 0, m_esc = 0, m_brk = 0;
   logic       e_close, e_bs, e_be, e_dv;
   logic [4:0] e_stat;
   logic [7:0] e_dd;
   string      e_tag;

   task automatic model(input logic v, input logic [7:0] b, input logic bk,
                        input logic id, input logic c, input logic ov,
                        input logic ok, input logic md);
      logic [7:0] ab;
      e_close = 0; e_stat = 0; e_bs = 0; e_be = 0; e_dv = 0; e_dd = 0; e_tag = "R1";
      if (c) begin
         if (v && bk && !ov) begin
            if (!m_brk) begin e_bs = 1; e_tag = "R8"; end
            m_brk = 1;
         end else if ((v && !bk && !ov) || id) begin
            if (m_brk) begin e_be = 1; e_tag = "R9"; end
            m_brk = 0;
         end
      end
      ab = md ? 8'hC1 : 8'h7E;
      if (m_st == 2) begin
         if (c) m_st = 0;
      end else if (!c) begin
         if (m_has) begin e_close = 1; e_stat = 5'b10000; e_tag = "R6"; end
         m_st = 2; m_has = 0; m_esc = 0;
      end else if (ov) begin
         if (m_has) begin e_close = 1; e_stat = 5'b01000; e_tag = "R7"; end
         m_st = 0; m_has = 0; m_esc = 0;
      end else if (v && bk) begin
         if (m_has) begin e_close = 1; e_stat = 5'b00010; e_tag = "R8"; end
         m_st = 0; m_has = 0; m_esc = 0;
      end else if (v) begin
         if (m_esc && b == ab) begin
            e_close = 1; e_stat = 5'b00100; e_tag = "R5";
            m_st = 0; m_has = 0; m_esc = 0;
         end else if (b == 8'h7E) begin
            m_esc = 0;
            if (m_st == 1 && m_has) begin
               e_close = 1; e_stat = ok ? 5'b0 : 5'b00001; e_tag = "R3";
            end else if (m_st == 1) e_tag = "R4";
            m_st = 1; m_has = 0;
         end else if (m_esc) begin
            m_esc = 0;
            if (m_st == 1) begin e_dv = 1; e_dd = b ^ 8'h20; m_has = 1; e_tag = "R2"; end
         end else if (b == 8'h7D) begin
            m_esc = 1; e_tag = "R2";
         end else if (m_st == 1) begin
            e_dv = 1; e_dd = b; m_has = 1;
         end
      end
   endtask

   task automatic step(input logic v, input logic [7:0] b, input logic bk = 0,
                       input logic id = 0, input logic c = 1, input logic ov = 0,
                       input logic ok = 1, input logic md = 0, input string tag = "");
      logic [18:0] act, exp;
      @(negedge clk);
      vld = v; byt = b; brk = bk; idle = id; cd = c; ovr = ov; crc_ok = ok; mode = md;
      model(v, b, bk, id, c, ov, ok, md);
      @(posedge clk);
      #1;
      act = {close_w, stat_w, rxf_w, bs_w, be_w, dv_w, data_w};
      exp = {e_close, e_stat, e_close, e_bs, e_be, e_dv, e_dd};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", (tag != "") ? tag : e_tag, act, exp);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      int          cd_hold;
      logic        rmode;
      rst_n = 0; vld = 0; byt = 0; brk = 0; idle = 0; cd = 1; ovr = 0; crc_ok = 1; mode = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1 reset state
      step(0, 8'h00, .tag("R1"));
      // R1 hunt drops bytes, flag opens, data passes
      step(1, 8'h11, .tag("R1"));
      step(1, 8'h7E, .tag("R1"));
      step(1, 8'h41, .tag("R1"));
      // R2 escapes
      step(1, 8'h7D, .tag("R2"));
      step(1, 8'h5E, .tag("R2"));
      step(1, 8'h7D, .tag("R2"));
      step(1, 8'h5D, .tag("R2"));
      // R3 good close then CRC error close
      step(1, 8'h7E, .ok(1), .tag("R3"));
      step(1, 8'h22, .tag("R3"));
      step(1, 8'h7E, .ok(0), .tag("R3"));
      // R4 empty frame
      step(1, 8'h7E, .ok(0), .tag("R4"));
      // R5 abort in frame (mode 0) and with no frame (mode 1)
      step(1, 8'h33, .tag("R5"));
      step(1, 8'h7D, .tag("R5"));
      step(1, 8'h7E, .ok(0), .tag("R5"));
      step(1, 8'h7D, .md(1), .tag("R5"));
      step(1, 8'hC1, .md(1), .tag("R5"));
      step(1, 8'h7D, .md(1), .tag("R5"));
      step(1, 8'h7E, .md(1), .tag("R5"));
      step(1, 8'h01, .md(1), .tag("R5"));
      // R6 carrier loss
      step(1, 8'h7E, .tag("R6"));
      step(1, 8'h44, .tag("R6"));
      step(1, 8'h7E, .c(0), .tag("R6"));
      step(1, 8'h45, .c(0), .tag("R6"));
      step(1, 8'h7E, .c(1), .tag("R6"));
      step(1, 8'h55, .tag("R6"));
      step(1, 8'h7E, .tag("R6"));
      step(1, 8'h66, .tag("R6"));
      // R7 overrun
      step(1, 8'h77, .ov(1), .tag("R7"));
      step(1, 8'h78, .tag("R7"));
      // R8 / R9 breaks
      step(1, 8'h7E, .tag("R8"));
      step(1, 8'h12, .tag("R8"));
      step(1, 8'h00, .bk(1), .tag("R8"));
      step(1, 8'h00, .bk(1), .tag("R8"));
      step(0, 8'h00, .id(1), .tag("R9"));
      step(1, 8'h00, .bk(1), .tag("R8"));
      step(1, 8'h00, .tag("R9"));
      // R10 priority
      step(1, 8'h7E, .tag("R10"));
      step(1, 8'h13, .tag("R10"));
      step(1, 8'h7E, .c(0), .ov(1), .ok(0), .tag("R10"));
      step(0, 8'h00, .tag("R10"));
      step(1, 8'h7E, .tag("R10"));
      step(1, 8'h14, .tag("R10"));
      step(1, 8'h00, .bk(1), .ov(1), .tag("R10"));
      step(1, 8'h7E, .tag("R10"));
      step(1, 8'h15, .tag("R10"));
      step(1, 8'h7D, .tag("R10"));
      step(1, 8'h7E, .ok(0), .tag("R10"));

      // constrained random traffic
      seed = 32'h5EED_1234;
      void'($urandom(seed));
      cd_hold = 0;
      rmode = 0;
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         logic [7:0]  b;
         logic        c;
         if (i % 250 == 0) rmode = $urandom_range(0, 1);
         r = $urandom_range(0, 99);
         if (r < 25)      b = 8'h7E;
         else if (r < 37) b = 8'h7D;
         else if (r < 42) b = 8'hC1;
         else             b = 8'($urandom);
         if (cd_hold > 0) cd_hold--;
         else if ($urandom_range(0, 79) == 0) cd_hold = $urandom_range(1, 4);
         c = (cd_hold == 0);
         step($urandom_range(0, 9) < 8, b,
              $urandom_range(0, 39) == 0,
              $urandom_range(0, 29) == 0,
              c,
              $urandom_range(0, 59) == 0,
              $urandom_range(0, 3) != 0,
              rmode);
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule